// File: doc/BRIEF.md
# Eight-bit accumulator processor core with overlapped fetch

The core is a small Harvard-architecture processor with an 8-bit accumulator. Program words are 16 bits wide and come from a separate instruction memory. Each word holds two bytes. The upper byte is the opcode and the lower byte is an operand, used either as an immediate value or as an address. The core keeps an accumulator, two index registers (X, Y), an output register and a 16-bit program counter.

A fetch happens on every clock edge. The word being fetched is latched while the previously latched word executes. As a result, one instruction retires per clock, and the instruction placed right after any jump always runs.

The opcode byte has three fields:
- bits [7:5] select the operation class;
- bits [4:2] select the addressing and destination mode;
- bits [1:0] select the source that drives the internal data bus.

The data memory port reads combinationally and writes on the clock edge. Its address comes either from the operand byte alone or from the index registers.

Top module: `accu_core`

## Requirements
- R1: While `rst_n` is low, `rom_addr` is 0x0000, `ram_we` is 0 and `out_port` is 0x00. After release, the first word executed is the one at ROM address 0.
- R2: Opcode bits [7:5] select the operation applied to the accumulator and the bus value: 0 load, 1 AND, 2 OR, 3 XOR, 4 add (mod 256), 5 subtract (mod 256).
- R3: Opcode bits [1:0] select the bus source: 0 the operand byte, 1 the data memory read value, 2 the accumulator, 3 the constant 0x00.
- R4: Class 6 is a store. It drives the bus value on `ram_wdata` with `ram_we` high for exactly one cycle and leaves the accumulator unchanged.
- R5: Mode bits [4:2] form the data address: 0 gives {0x00,D}, 1 gives {0x00,X}, 2 gives {Y,D}, 3 gives {Y,X}. Modes 4, 5 and 6 use {0x00,D}, and mode 7 uses {Y,X}.
- R6: For classes 0 to 5, mode 4 writes the result to X, mode 5 writes it to Y, and modes 6 and 7 write it to the output register, in each case instead of the accumulator.
- R7: Mode 7 increments X by one after the access. This applies to stores as well.
- R8: The word that follows a jump in ROM always executes before the jump target.
- R9: Class 7 with modes 1 to 7 is a jump within the current page. It replaces only the low PC byte with the bus value. The condition tests the accumulator: 1 greater than zero, 2 negative, 3 nonzero, 4 zero, 5 not negative, 6 zero or negative, 7 always.
- R10: Class 7 with mode 0 is an unconditional far jump to {Y, bus}.
- R11: When no jump is taken, the ROM address advances by one on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | 16 | Instruction memory address (program counter) |
| rom_data | input | 16 | Instruction word at `rom_addr` |
| ram_addr | output | 16 | Data memory address |
| ram_rdata | input | 8 | Data memory read value for `ram_addr` |
| ram_wdata | output | 8 | Data memory write value |
| ram_we | output | 1 | Data memory write enable |
| out_port | output | 8 | Output register |

## Verification
A directed program drives the core. A scoreboard expects a precise sequence of memory writes and output-register changes.

The arithmetic and logic chain passes distinct bit patterns through every operation class. A wrong class decode therefore produces a different stored byte.

Stores use every address form, including an X post-increment followed by a store to the next location. This separates the zero-page, indexed and paged addressing.

Each jump condition is tried with a positive, a zero and a negative accumulator, in both the taken and the untaken direction. Every slot that must be skipped holds a trap store, so a wrong target or a missing delay slot shows up as an unexpected write.

// File: rtl/accu_pkg.sv
package accu_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam int IW = 2 * DW;

    typedef enum logic [2:0] {
        OP_LD  = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_ADD = 3'd4,
        OP_SUB = 3'd5,
        OP_ST  = 3'd6,
        OP_BR  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SRC_D    = 2'd0,
        SRC_RAM  = 2'd1,
        SRC_AC   = 2'd2,
        SRC_ZERO = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        DST_AC  = 2'd0,
        DST_X   = 2'd1,
        DST_Y   = 2'd2,
        DST_OUT = 2'd3
    } dst_e;

    typedef struct packed {
        op_e           op;
        logic [2:0]    mode;
        src_e          src;
        logic [DW-1:0] d;
        logic          hi_from_y;
        logic          lo_from_x;
        dst_e          dst;
        logic          x_inc;
        logic          is_store;
        logic          is_jump;
        logic          is_far;
    } ctrl_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [IW-1:0] ir;
        logic [DW-1:0] acc;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [DW-1:0] outr;
    } state_t;
endpackage

// File: rtl/accu_decode.sv
module accu_decode
    import accu_pkg::*;
(
    input  logic [IW-1:0] ir,
    output ctrl_t         ctrl
);
    always_comb begin
        ctrl           = '0;
        ctrl.op        = op_e'(ir[IW-1 -: 3]);
        ctrl.mode      = ir[IW-4 -: 3];
        ctrl.src       = src_e'(ir[DW+1 -: 2]);
        ctrl.d         = ir[DW-1:0];
        ctrl.is_store  = (ctrl.op == OP_ST);
        ctrl.is_jump   = (ctrl.op == OP_BR);
        ctrl.is_far    = ctrl.is_jump && (ctrl.mode == 3'd0);
        ctrl.dst       = DST_AC;
        ctrl.hi_from_y = 1'b0;
        ctrl.lo_from_x = 1'b0;
        ctrl.x_inc     = 1'b0;
        if (!ctrl.is_jump) begin
            case (ctrl.mode)
                3'd0: ctrl.dst = DST_AC;
                3'd1: ctrl.lo_from_x = 1'b1;
                3'd2: ctrl.hi_from_y = 1'b1;
                3'd3: begin
                    ctrl.hi_from_y = 1'b1;
                    ctrl.lo_from_x = 1'b1;
                end
                3'd4: ctrl.dst = DST_X;
                3'd5: ctrl.dst = DST_Y;
                3'd6: ctrl.dst = DST_OUT;
                default: begin
                    ctrl.hi_from_y = 1'b1;
                    ctrl.lo_from_x = 1'b1;
                    ctrl.dst       = DST_OUT;
                    ctrl.x_inc     = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/accu_alu.sv
module accu_alu
    import accu_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] bval,
    output logic [DW-1:0] res
);
    always_comb begin
        case (op)
            OP_LD:   res = bval;
            OP_AND:  res = acc & bval;
            OP_OR:   res = acc | bval;
            OP_XOR:  res = acc ^ bval;
            OP_ADD:  res = acc + bval;
            OP_SUB:  res = acc - bval;
            default: res = acc;
        endcase
    end
endmodule

// File: rtl/accu_cond.sv
module accu_cond
    import accu_pkg::*;
(
    input  logic [2:0]    mode,
    input  logic [DW-1:0] acc,
    output logic          take
);
    logic neg, zero;
    always_comb begin
        neg  = acc[DW-1];
        zero = (acc == '0);
        case (mode)
            3'd0:    take = 1'b1;
            3'd1:    take = !neg && !zero;
            3'd2:    take = neg;
            3'd3:    take = !zero;
            3'd4:    take = zero;
            3'd5:    take = !neg;
            3'd6:    take = neg || zero;
            default: take = 1'b1;
        endcase
    end
endmodule

// File: rtl/accu_core.sv
module accu_core
    import accu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] rom_addr,
    input  logic [IW-1:0] rom_data,
    output logic [AW-1:0] ram_addr,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    output logic [DW-1:0] out_port
);
    state_t        st_q, st_d;
    ctrl_t         ctrl;
    logic [DW-1:0] bus_val;
    logic [DW-1:0] alu_res;
    logic          take;

    logic [IW-1:0] ir_q;
    logic [DW-1:0] acc_q, x_q, y_q;

    accu_decode u_dec (.ir(st_q.ir), .ctrl(ctrl));

    accu_alu u_alu (.op(ctrl.op), .acc(st_q.acc), .bval(bus_val), .res(alu_res));

    accu_cond u_cond (.mode(ctrl.mode), .acc(st_q.acc), .take(take));

    always_comb begin
        case (ctrl.src)
            SRC_D:    bus_val = ctrl.d;
            SRC_RAM:  bus_val = ram_rdata;
            SRC_AC:   bus_val = st_q.acc;
            default:  bus_val = '0;
        endcase

        ram_addr  = {(ctrl.hi_from_y ? st_q.y : {DW{1'b0}}),
                     (ctrl.lo_from_x ? st_q.x : ctrl.d)};
        ram_we    = ctrl.is_store;
        ram_wdata = bus_val;

        st_d    = st_q;
        st_d.ir = rom_data;
        st_d.pc = st_q.pc + 1'b1;

        if (ctrl.is_jump) begin
            if (ctrl.is_far)
                st_d.pc = {st_q.y, bus_val};
            else if (take)
                st_d.pc = {st_q.pc[AW-1:DW], bus_val};
        end else begin
            if (!ctrl.is_store) begin
                case (ctrl.dst)
                    DST_AC:  st_d.acc  = alu_res;
                    DST_X:   st_d.x    = alu_res;
                    DST_Y:   st_d.y    = alu_res;
                    default: st_d.outr = alu_res;
                endcase
            end
            if (ctrl.x_inc)
                st_d.x = st_q.x + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rom_addr = st_q.pc;
    assign out_port = st_q.outr;
    assign ir_q     = st_q.ir;
    assign acc_q    = st_q.acc;
    assign x_q      = st_q.x;
    assign y_q      = st_q.y;
endmodule

// File: rtl/accu_core_chk.sv
module accu_core_chk
    import accu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] rom_addr,
    input logic          ram_we,
    input logic [IW-1:0] ir_q,
    input logic [DW-1:0] acc_q,
    input logic [DW-1:0] x_q,
    input logic [DW-1:0] y_q
);
    logic [2:0] cls, md;
    assign cls = ir_q[IW-1 -: 3];
    assign md  = ir_q[IW-4 -: 3];

    // R1: reset holds the fetch address at zero
    p_reset_pc_r1: assert property (@(posedge clk)
        !rst_n |=> rom_addr == '0);

    // R4: a store leaves the accumulator untouched
    p_store_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> $stable(acc_q));

    // R11: sequential fetch when no jump executes
    p_seq_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cls != 3'd7) |=> rom_addr == $past(rom_addr) + 1'b1);

    // R9: in-page jump keeps the high PC byte
    p_page_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == 3'd7 && md != 3'd0) |=> rom_addr[AW-1:DW] == $past(rom_addr[AW-1:DW]));

    // R10: far jump high byte comes from Y
    p_far_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == 3'd7 && md == 3'd0) |=> rom_addr[AW-1:DW] == $past(y_q));

    // R7: post-increment of X
    p_x_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cls != 3'd7 && md == 3'd7) |=> x_q == $past(x_q) + 1'b1);

    // R9: jumps never alter the accumulator
    p_jump_keeps_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == 3'd7) |=> $stable(acc_q));
endmodule

bind accu_core accu_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rom_addr (rom_addr),
    .ram_we   (ram_we),
    .ir_q     (ir_q),
    .acc_q    (acc_q),
    .x_q      (x_q),
    .y_q      (y_q)
);

// File: tb/accu_core_bench.sv
module accu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] rom_addr, rom_data, ram_addr;
    logic [7:0]  ram_rdata, ram_wdata, out_port;
    logic        ram_we;

    always #10 clk = ~clk;

    accu_core u_accu_core (
        .clk(clk), .rst_n(rst_n),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .ram_wdata(ram_wdata), .ram_we(ram_we),
        .out_port(out_port)
    );

    function automatic logic [15:0] ins(input int op, input int md, input int src, input int d);
        return {op[2:0], md[2:0], src[1:0], d[7:0]};
    endfunction

    // trap: store AC to [$FF]; any stray execution shows as an unexpected write
    function automatic logic [15:0] rom_word(input logic [15:0] a);
        case (a)
            16'h0000: return ins(0,0,0,'h5A);
            16'h0001: return ins(6,0,2,'h10);
            16'h0002: return ins(4,0,0,'h10);
            16'h0003: return ins(6,0,2,'h11);
            16'h0004: return ins(1,0,0,'h0F);
            16'h0005: return ins(2,0,0,'h30);
            16'h0006: return ins(3,0,0,'hFF);
            16'h0007: return ins(5,0,0,'h05);
            16'h0008: return ins(6,0,2,'h12);
            16'h0009: return ins(6,0,0,'h13);
            16'h000A: return ins(6,0,2,'h14);
            16'h000B: return ins(0,0,1,'h11);
            16'h000C: return ins(0,4,0,'h01);
            16'h000D: return ins(0,5,0,'h02);
            16'h000E: return ins(6,3,2,'h00);
            16'h000F: return ins(6,2,2,'h40);
            16'h0010: return ins(6,7,2,'h00);
            16'h0011: return ins(6,3,2,'h00);
            16'h0012: return ins(0,6,0,'hA5);
            16'h0013: return ins(7,3,0,'h18);
            16'h0014: return ins(0,0,0,'h03);
            16'h0018: return ins(6,0,2,'h21);
            16'h0019: return ins(0,0,0,'h00);
            16'h001A: return ins(7,3,0,'h1E);
            16'h001B: return ins(6,0,2,'h22);
            16'h001C: return ins(0,0,0,'h11);
            16'h001D: return ins(6,0,2,'h23);
            16'h001E: return ins(0,0,0,'h99);
            16'h001F: return ins(6,0,2,'h24);
            16'h0020: return ins(0,0,0,'h80);
            16'h0021: return ins(7,5,0,'h28);
            16'h0022: return ins(2,0,0,'h00);
            16'h0023: return ins(7,2,0,'h28);
            16'h0024: return ins(6,0,2,'h25);
            16'h0028: return ins(0,0,0,'h00);
            16'h0029: return ins(7,4,0,'h2E);
            16'h002A: return ins(0,0,0,'h7F);
            16'h002E: return ins(6,0,2,'h28);
            16'h002F: return ins(7,1,0,'h33);
            16'h0030: return ins(5,0,0,'h7F);
            16'h0033: return ins(7,6,0,'h36);
            16'h0034: return ins(0,0,0,'hFF);
            16'h0036: return ins(0,5,0,'h01);
            16'h0037: return ins(7,0,0,'h10);
            16'h0038: return ins(6,0,2,'h2B);
            16'h0110: return ins(0,6,0,'hC3);
            16'h0111: return ins(7,7,0,'h20);
            16'h0112: return ins(0,6,0,'h3C);
            16'h0120: return ins(6,0,2,'h2E);
            16'h0121: return ins(0,6,2,'h00);
            16'h0122: return ins(7,7,0,'h22);
            16'h0123: return ins(2,0,0,'h00);
            default:  return ins(6,0,2,'hFF);
        endcase
    endfunction

    logic [7:0] mem [0:1023];
    assign rom_data  = rom_word(rom_addr);
    assign ram_rdata = mem[ram_addr[9:0]];
    always @(posedge clk) if (ram_we) mem[ram_addr[9:0]] <= ram_wdata;

    typedef struct {
        bit         is_out;
        logic [15:0] addr;
        logic [7:0]  data;
        string       req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    mon_en = 0;
    bit    done   = 0;
    logic [7:0] last_out;

    task automatic push(input bit is_out, input logic [15:0] a, input logic [7:0] d, input string r);
        item_t it;
        it.is_out = is_out; it.addr = a; it.data = d; it.req = r;
        q.push_back(it);
    endtask

    task automatic check(input bit ok, input string r, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic observe(input bit is_out, input logic [15:0] a, input logic [7:0] d);
        item_t it;
        if (q.size() == 0) begin
            check(0, "R8", is_out ? "unexpected output change" : "unexpected write",
                  {a, 8'h00, d}, 32'h0);
        end else begin
            it = q.pop_front();
            check(it.is_out == is_out && (is_out || it.addr == a) && it.data == d,
                  it.req, is_out ? "out event" : "write event",
                  {7'h0, is_out, a, d}, {7'h0, it.is_out, it.addr, it.data});
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (out_port !== last_out) begin
                observe(1, 16'h0, out_port);
                last_out = out_port;
            end
            if (ram_we) observe(0, ram_addr, ram_wdata);
        end
    end

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        rst_n = 1'b0;
        // expected event order
        push(0, 16'h0010, 8'h5A, "R3");   // immediate load, store AC
        push(0, 16'h0011, 8'h6A, "R2");   // add
        push(0, 16'h0012, 8'hC0, "R2");   // and/or/xor/sub chain
        push(0, 16'h0013, 8'h13, "R3");   // store immediate source
        push(0, 16'h0014, 8'hC0, "R4");   // AC kept through stores
        push(0, 16'h0201, 8'h6A, "R5");   // RAM read load, Y:X address
        push(0, 16'h0240, 8'h6A, "R5");   // Y:D address
        push(0, 16'h0201, 8'h6A, "R7");   // Y:X then X++
        push(0, 16'h0202, 8'h6A, "R7");   // incremented X
        push(1, 16'h0000, 8'hA5, "R6");   // output destination
        push(0, 16'h0021, 8'h03, "R8");   // delay slot after taken nonzero
        push(0, 16'h0022, 8'h00, "R8");   // delay slot after untaken
        push(0, 16'h0023, 8'h11, "R9");   // nonzero not taken on zero
        push(0, 16'h0024, 8'h99, "R11");
        push(0, 16'h0025, 8'h80, "R9");   // ge untaken, lt taken on negative
        push(0, 16'h0028, 8'h7F, "R9");   // eq taken on zero
        push(0, 16'h002B, 8'hFF, "R9");   // gt and le taken
        push(1, 16'h0000, 8'hC3, "R10");  // far jump to {Y,D}
        push(1, 16'h0000, 8'h3C, "R8");   // delay slot of in-page jump
        push(0, 16'h002E, 8'hFF, "R9");   // always-jump target in page 1
        push(1, 16'h0000, 8'hFF, "R3");   // AC as bus source to output

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rom_addr == 16'h0000, "R1", "rom_addr in reset", rom_addr, 0);
        check(ram_we == 1'b0,       "R1", "ram_we in reset",   ram_we,   0);
        check(out_port == 8'h00,    "R1", "out_port in reset", out_port, 0);
        last_out = out_port;
        rst_n  = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        check(rom_addr == 16'h0001, "R11", "first fetch advance", rom_addr, 16'h0001);
        for (int i = 0; i < 400 && q.size() != 0; i++) @(negedge clk);
        repeat (30) @(negedge clk);
        check(q.size() == 0, "R8", "events still pending", q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule